// File: doc/BRIEF.md
# Mailbox Request Sequencer

This engine carries one command from the host to a remote agent over a pair of four-register mailboxes and brings back the reply. A single start pulse latches three things: a 256-bit command image (register k is bits `64k+63:64k`), a 4-bit mask naming the request registers to write, and a 4-bit mask naming the response registers to read. The engine writes the selected request registers and then rings the remote doorbell. It polls the local doorbell until the reply flag appears or a programmable number of polls has gone by.

When the reply flag appears, the engine reads the selected response registers and clears the flag. It then compares the reply header with the request header. Completion is reported by a one-cycle `done` pulse. At that point two error flags, the captured response image and the two status words are valid, and they stay valid until the next accepted start.

The bus port is a simple single-cycle register port. A write completes in the cycle in which `bus_req` and `bus_we` are high. A read returns `bus_rdata` combinationally in the same cycle. Register addresses are: request mailbox 0..3, response mailbox 4..7, remote doorbell set alias 10, local doorbell 11, local doorbell clear alias 12.

Top module: `mbox_seq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err_timeout`, `err_mismatch` and `bus_req` are low.
- R2: After a start, request register k (address k) is written with image word k only when request mask bit k is set. No other request address is written.
- R3: Request register 0 goes out with bits 63:48 forced to zero and bits 47:32 and 15:0 taken from the image. Bits 31:16 carry a sequence ID that is 0 for the first accepted start after reset and goes up by one for each accepted start after that.
- R4: Once the request writes are done, the engine makes exactly one write of `0x8000_0000_0000_0000` to address 10.
- R5: The engine then reads address 11 once per cycle until bit 63 is seen set. After that it reads response register 4+k only when response mask bit k is set.
- R6: After the response reads, the engine writes `0x7FFF_FFFF_FFFF_FFFF` to address 12 exactly once.
- R7: The poll limit is T polls that find bit 63 clear, where a T of zero counts as one. When that limit is reached, `done` pulses with `err_timeout` set and `err_mismatch` clear. No response register is read and address 12 is not written.
- R8: At reset and at each accepted start, the response image is preset. Word 0, the header (primary status, secondary status, sequence ID, class, command from bit 63 down), becomes all ones, and words 1..3 become zero. Words that are not read keep these values.
- R9: If the captured header bits 31:0 (sequence ID, class, command) differ from the request's, `err_mismatch` is set. Otherwise `err_mismatch` stays clear and `rsp_primary`/`rsp_secondary` show header bits 63:48 and 47:32.
- R10: A start while `busy` is high is ignored and starts no transfer. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| cmd_img | input | 256 | Request image, word k = register k |
| req_mask | input | 4 | Request registers to write |
| rsp_mask | input | 4 | Response registers to read |
| poll_limit | input | 32 | Maximum unsuccessful polls |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Reply flag never seen |
| err_mismatch | output | 1 | Reply header differs from request |
| rsp_img | output | 256 | Captured response image |
| rsp_primary | output | 16 | Primary status from the captured header |
| rsp_secondary | output | 16 | Secondary status from the captured header |
| bus_req | output | 1 | Register access strobe |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, same cycle |

## Verification
The hardest case to reach is the poll-limit boundary, where the reply flag shows up on exactly the last allowed poll or exactly one poll too late. The bench's bus model raises the local flag a chosen number of cycles after the doorbell write. With no delay, the flag is first visible on the second poll. A limit of 1 therefore times out and a limit of 2 succeeds, and both cases are in the vector table. The mismatch paths are reached in two ways: by having the model return a corrupted sequence ID or command byte, and by leaving response register 4 out of the read mask so that the preset header is what gets compared.

// File: rtl/mbox_seq_engine.sv
module mbox_seq_engine #(
  parameter int DW   = 64,
  parameter int NREG = 4,
  parameter int TW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NREG*DW-1:0]   cmd_img,
  input  logic [NREG-1:0]      req_mask,
  input  logic [NREG-1:0]      rsp_mask,
  input  logic [TW-1:0]        poll_limit,
  output logic                 busy,
  output logic                 done,
  output logic                 err_timeout,
  output logic                 err_mismatch,
  output logic [NREG*DW-1:0]   rsp_img,
  output logic [15:0]          rsp_primary,
  output logic [15:0]          rsp_secondary,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [$clog2(2*NREG+6)-1:0] bus_addr,
  output logic [DW-1:0]        bus_wdata,
  input  logic [DW-1:0]        bus_rdata
);
  localparam int IW = NREG * DW;
  localparam int XW = $clog2(NREG);
  localparam int AW = $clog2(2*NREG+6);
  localparam logic [AW-1:0] A_RING = AW'(2*NREG+2);
  localparam logic [AW-1:0] A_POLL = AW'(2*NREG+3);
  localparam logic [AW-1:0] A_CLR  = AW'(2*NREG+4);
  localparam logic [IW-1:0] PRESET = {{(IW-DW){1'b0}}, {DW{1'b1}}};
  localparam logic [DW-1:0] RING_V = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CLR_V  = {1'b0, {(DW-1){1'b1}}};

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RING, S_POLL, S_RD, S_CLR, S_END} st_t;
  st_t st;

  logic [XW-1:0]   idx;
  logic [IW-1:0]   req_q, rsp_q;
  logic [NREG-1:0] rqm, rsm;
  logic [TW-1:0]   lim_q, pcnt;
  logic [15:0]     seq_q;
  logic            last;

  assign last = (idx == XW'(NREG-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; req_q <= '0; rsp_q <= PRESET;
      rqm <= '0; rsm <= '0; lim_q <= '0; pcnt <= '0; seq_q <= '0;
      err_timeout <= 1'b0; err_mismatch <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          req_q <= {cmd_img[IW-1:DW], 16'h0, cmd_img[47:32], seq_q, cmd_img[15:0]};
          seq_q <= seq_q + 16'd1;
          rqm <= req_mask; rsm <= rsp_mask; lim_q <= poll_limit;
          rsp_q <= PRESET; err_timeout <= 1'b0; err_mismatch <= 1'b0;
          idx <= '0; st <= S_WR;
        end
        S_WR: begin
          idx <= idx + 1'b1;
          if (last) st <= S_RING;
        end
        S_RING: begin pcnt <= '0; st <= S_POLL; end
        S_POLL: begin
          if (bus_rdata[DW-1]) begin
            idx <= '0; st <= S_RD;
          end else if ((TW+1)'(pcnt) + 1'b1 >= (TW+1)'(lim_q)) begin
            err_timeout <= 1'b1; st <= S_END;
          end else pcnt <= pcnt + 1'b1;
        end
        S_RD: begin
          if (rsm[idx]) rsp_q[idx*DW +: DW] <= bus_rdata;
          idx <= idx + 1'b1;
          if (last) st <= S_CLR;
        end
        S_CLR: begin
          err_mismatch <= (rsp_q[31:0] != req_q[31:0]);
          st <= S_END;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    case (st)
      S_WR:   begin bus_req = rqm[idx]; bus_we = 1'b1; bus_addr = AW'(idx);
                    bus_wdata = req_q[idx*DW +: DW]; end
      S_RING: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_RING; bus_wdata = RING_V; end
      S_POLL: begin bus_req = 1'b1; bus_addr = A_POLL; end
      S_RD:   begin bus_req = rsm[idx]; bus_addr = AW'(NREG) + AW'(idx); end
      S_CLR:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = CLR_V; end
      default: ;
    endcase
  end

  assign busy          = (st != S_IDLE);
  assign done          = (st == S_END);
  assign rsp_img       = rsp_q;
  assign rsp_primary   = rsp_q[63:48];
  assign rsp_secondary = rsp_q[47:32];
endmodule

// File: rtl/mbox_seq_engine_chk.sv
module mbox_seq_engine_chk #(
  parameter int DW = 64,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err_timeout,
  input logic          err_mismatch,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r4_ring_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == AW'(10)) |-> bus_wdata == {1'b1, {(DW-1){1'b0}}});
  a_r6_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == AW'(12)) |-> bus_wdata == {1'b0, {(DW-1){1'b1}}});
  a_r2_write_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_addr < AW'(4) || bus_addr == AW'(10) || bus_addr == AW'(12)));
  a_r5_read_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |-> ((bus_addr >= AW'(4) && bus_addr < AW'(8)) || bus_addr == AW'(11)));
  a_r7_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_timeout && err_mismatch));
endmodule

bind mbox_seq_engine mbox_seq_engine_chk #(.DW(DW), .AW($clog2(2*NREG+6))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_timeout(err_timeout), .err_mismatch(err_mismatch), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

// File: tb/sim_mbox_seq_engine.sv
module sim_mbox_seq_engine;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [255:0] cmd_img = '0;
  logic [3:0] req_mask = '0, rsp_mask = '0;
  logic [31:0] poll_limit = '0;
  logic busy, done, err_timeout, err_mismatch, bus_req, bus_we;
  logic [255:0] rsp_img;
  logic [15:0] rsp_primary, rsp_secondary;
  logic [3:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  mbox_seq_engine u0 (.*);

  logic mdl_clr = 1'b0;
  int unsigned dly_cfg = 0;
  logic [255:0] rsp_src = '0;
  logic [3:0] wr_mask, rd_mask;
  logic [63:0] wr_val [4];
  int unsigned ring_n, clr_n, dly;
  logic armed;
  logic [63:0] local_db;

  always @(posedge clk) begin
    if (mdl_clr) begin
      wr_mask <= '0; rd_mask <= '0; ring_n <= 0; clr_n <= 0;
      local_db <= '0; armed <= 1'b0; dly <= 0;
      for (int k = 0; k < 4; k++) wr_val[k] <= '0;
    end else begin
      if (bus_req && bus_we) begin
        if (bus_addr < 4) begin
          wr_mask[bus_addr[1:0]] <= 1'b1; wr_val[bus_addr[1:0]] <= bus_wdata;
        end
        if (bus_addr == 10 && bus_wdata[63]) begin
          ring_n <= ring_n + 1; armed <= 1'b1; dly <= dly_cfg;
        end
        if (bus_addr == 12) begin clr_n <= clr_n + 1; local_db <= local_db & bus_wdata; end
      end
      if (bus_req && !bus_we && bus_addr >= 4 && bus_addr < 8) rd_mask[bus_addr[1:0]] <= 1'b1;
      if (armed) begin
        if (dly == 0) begin local_db[63] <= 1'b1; armed <= 1'b0; end
        else dly <= dly - 1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr >= 4 && bus_addr < 8) bus_rdata = rsp_src[bus_addr[1:0]*64 +: 64];
    else if (bus_addr == 11) bus_rdata = local_db;
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  localparam int NV = 8;
  localparam logic [3:0] V_RQM [NV] = '{4'hF, 4'h1, 4'h5, 4'h3, 4'hF, 4'h9, 4'h0, 4'hE};
  localparam logic [3:0] V_RSM [NV] = '{4'hF, 4'h1, 4'hA, 4'h3, 4'hF, 4'h7, 4'h1, 4'hD};
  localparam int V_DLY [NV] = '{3, 0, 4, 2, 0, 10, 1, 5};
  localparam int V_LIM [NV] = '{100, 2, 100, 100, 1, 0, 50, 100};
  localparam int V_BAD [NV] = '{0, 0, 0, 1, 0, 0, 0, 2};

  logic [15:0] exp_seq = 16'd0;
  localparam logic [255:0] PRE = {192'h0, 64'hFFFF_FFFF_FFFF_FFFF};

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) chk(1'b0, "R10 watchdog waiting for done", 0, 1);
  endtask

  task automatic run_vec(input int i, input bit poke_busy);
    logic [63:0] w [4];
    logic [63:0] r [4];
    logic [255:0] exp_img;
    logic [63:0] exp_r0;
    bit ok, to, mm;
    int eff;
    for (int k = 0; k < 4; k++) w[k] = {32'hA5A5_0000 + 32'(i), 16'(k), 16'(i * 7)};
    w[0] = {16'hDEAD, 16'h0100 + 16'(i), 16'hBEEF, 8'hD0 + 8'(i), 8'h10 + 8'(i)};
    r[0] = {16'h0010 + 16'(i), 16'h2000 + 16'(i), exp_seq, w[0][15:0]};
    if (V_BAD[i] == 1) r[0][31:16] = exp_seq ^ 16'h0001;
    if (V_BAD[i] == 2) r[0][7:0] = w[0][7:0] ^ 8'h80;
    for (int k = 1; k < 4; k++) r[k] = {32'hC0DE_0000 + 32'(k), 32'(i)};
    @(negedge clk);
    mdl_clr = 1'b1; dly_cfg = V_DLY[i]; rsp_src = {r[3], r[2], r[1], r[0]};
    @(negedge clk);
    mdl_clr = 1'b0;
    cmd_img = {w[3], w[2], w[1], w[0]}; req_mask = V_RQM[i]; rsp_mask = V_RSM[i];
    poll_limit = V_LIM[i]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      cmd_img = ~cmd_img; req_mask = 4'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    eff = (V_LIM[i] == 0) ? 1 : V_LIM[i];
    to = (eff < V_DLY[i] + 2);
    exp_img = PRE;
    if (!to) for (int k = 0; k < 4; k++) if (V_RSM[i][k]) exp_img[k*64 +: 64] = r[k];
    mm = !to && (exp_img[31:0] != {exp_seq, w[0][15:0]});
    exp_r0 = {16'h0, w[0][47:32], exp_seq, w[0][15:0]};
    chk(wr_mask == V_RQM[i], "R2 written request registers", 256'(wr_mask), 256'(V_RQM[i]));
    for (int k = 1; k < 4; k++)
      if (V_RQM[i][k]) chk(wr_val[k] == w[k], "R2 request word value", wr_val[k], w[k]);
    if (V_RQM[i][0]) chk(wr_val[0] == exp_r0, "R3 header word with sequence ID", wr_val[0], exp_r0);
    chk(ring_n == 1, "R4 doorbell rung once", ring_n, 1);
    chk(rd_mask == (to ? 4'h0 : V_RSM[i]), "R5 R7 response registers read", 256'(rd_mask),
        256'(to ? 4'h0 : V_RSM[i]));
    chk(clr_n == (to ? 0 : 1), "R6 R7 doorbell clear writes", clr_n, to ? 0 : 1);
    chk(err_timeout == to, "R7 timeout flag", 256'(err_timeout), 256'(to));
    chk(err_mismatch == mm, "R9 mismatch flag", 256'(err_mismatch), 256'(mm));
    chk(rsp_img == exp_img, "R8 response image", rsp_img, exp_img);
    chk({rsp_primary, rsp_secondary} == exp_img[63:32], "R9 status words",
        256'({rsp_primary, rsp_secondary}), 256'(exp_img[63:32]));
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", 256'(done), 0);
    chk(!busy, "R10 idle after done", 256'(busy), 0);
    exp_seq = exp_seq + 16'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_req, "R1 idle after reset", 256'({busy, done, bus_req}), 0);
    chk(!err_timeout && !err_mismatch, "R1 flags clear after reset",
        256'({err_timeout, err_mismatch}), 0);
    chk(rsp_img == PRE, "R8 preset after reset", rsp_img, PRE);
    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
    run_vec(0, 1'b1);
    repeat (20) @(negedge clk);
    chk(ring_n == 1 && !busy, "R10 start during busy ignored", 256'(ring_n), 1);
    run_vec(1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 global watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule